// File: doc/BRIEF.md
# Triggered One-Shot Delay Counter

This block is a single timer channel that produces one delayed interrupt pulse per start trigger. Software first writes the start bit, which enables the channel and fires the first countdown. Each later trigger comes from another start write or from a chosen edge on an external trigger pin. On every trigger the channel copies the delay value into a 16-bit down counter. It then decrements on the prescaled tick selected by the clock-select field. When a tick finds the counter at zero, the channel emits a one-clock interrupt pulse and parks at zero until the next trigger.

A stop write disables the channel and freezes the counter at whatever value it holds. The count is visible on an output at all times. The pin path has a two-flop synchroniser and an optional three-sample glitch filter. A unit-level enable, when low, returns every register of the channel to its reset value.

Top module: `delay_timer_channel`

## Requirements
- R1: A cycle with `startWr` high (and `stopWr` low) sets `enabled` to 1 and loads `countVal` with `delayData` at the next clock edge, whether or not the channel was enabled before.
- R2: While counting, `countVal` decrements by one only on cycles where `tickEn[clkSel]` is high; ticks on unselected lines have no effect.
- R3: With a loaded delay D, `irq` is high for exactly one clock after the (D+1)-th selected tick following the trigger; `countVal` then holds 0 and later ticks change nothing. D = 0 gives the pulse on the first tick.
- R4: A trigger that arrives during a countdown reloads `countVal` from `delayData` and restarts the delay. If it coincides with the final tick, the reload wins and no pulse is issued.
- R5: A cycle with `stopWr` high clears `enabled` and stops counting, and `countVal` keeps its value. If `startWr` is high in the same cycle, the stop wins.
- R6: With `edgeSel` = 1 (rising), 2 (falling) or 3 (both), a matching edge on `trigIn` acts as a trigger. With the filter off, the load appears 3 clocks after the first edge at which the new level is sampled. With `edgeSel` = 0, the pin is ignored.
- R7: Pin edges are ignored while `enabled` is 0; `countVal` is left unchanged.
- R8: With `filtEn` high, a `trigIn` pulse lasting one clock causes no trigger, while a level held at least 3 synchronised samples does. With `filtEn` low, the same one-clock pulse triggers.
- R9: After `rstN` is released, `countVal` = 0, `enabled` = 0 and `irq` = 0. A cycle with `unitEn` low restores this state at the next edge.
- R10: A change of `delayData` during a countdown does not disturb `countVal`; the new value is used only at the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| unitEn | input | 1 | Unit enable; low resets all channel registers synchronously |
| startWr | input | 1 | One-cycle write of the self-clearing start bit |
| stopWr | input | 1 | One-cycle write of the self-clearing stop bit |
| delayData | input | 16 | Delay value copied into the counter on each trigger |
| clkSel | input | 2 | Selects which prescaled tick drives counting |
| tickEn | input | 4 | Prescaled clock enables, one per selectable rate |
| edgeSel | input | 2 | Pin edge: 0 none, 1 rising, 2 falling, 3 both |
| filtEn | input | 1 | Enables the three-sample glitch filter on the pin |
| trigIn | input | 1 | Asynchronous external trigger pin |
| countVal | output | 16 | Current counter value |
| enabled | output | 1 | Channel enable status |
| irq | output | 1 | One-clock interrupt pulse at end of delay |

## Verification
The countdown is driven by long random runs. These mix sparse start and stop writes, random delay values including zero, random per-line tick patterns and occasional clock-select changes. They are compared cycle by cycle against a bench model. This exposes off-by-one errors in pulse timing, ticks taken from the wrong line, and wrong priority when start, stop and the final tick coincide. Directed pin sequences apply single rising and falling edges under each edge setting, one-clock glitches with the filter on and off, and edges while disabled. Each of these distinguishes a correct load from a missed or spurious one. Mid-countdown rewrites of the delay value show whether the counter is touched outside a trigger.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    EDGE_NONE    = 2'd0,
    EDGE_RISING  = 2'd1,
    EDGE_FALLING = 2'd2,
    EDGE_BOTH    = 2'd3
  } edgeMode_e;

  typedef struct packed {
    logic load;
    logic dec;
  } dlyStrobe_t;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       pinIn,
  input  logic       filtEn,
  input  logic [1:0] edgeSel,
  output logic       edgeHit
);
  import dly_pkg::*;
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [HIST_W-1:0]      hist;
  logic                   lvl, prevLvl, s, allHi, allLo, lvlNext;

  assign s     = syncQ[SYNC_STAGES-1];
  assign allHi = s & (&hist);
  assign allLo = ~s & ~(|hist);

  always_comb begin
    if (filtEn) begin
      if (allHi)      lvlNext = 1'b1;
      else if (allLo) lvlNext = 1'b0;
      else            lvlNext = lvl;
    end else begin
      lvlNext = s;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      hist    <= '0;
      lvl     <= 1'b0;
      prevLvl <= 1'b0;
    end else if (clear) begin
      syncQ   <= '0;
      hist    <= '0;
      lvl     <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinIn};
      hist    <= {hist[HIST_W-2:0], s};
      lvl     <= lvlNext;
      prevLvl <= lvl;
    end
  end

  always_comb begin
    unique case (edgeMode_e'(edgeSel))
      EDGE_RISING:  edgeHit = lvl & ~prevLvl;
      EDGE_FALLING: edgeHit = ~lvl & prevLvl;
      EDGE_BOTH:    edgeHit = lvl ^ prevLvl;
      default:      edgeHit = 1'b0;
    endcase
  end

  // R8
  filt_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && !clear && allHi) |=> lvl);
endmodule

// File: rtl/dly_datapath.sv
module dly_datapath #(
  parameter int CNT_W = dly_pkg::CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  dly_pkg::dlyStrobe_t strb,
  input  logic [CNT_W-1:0]    loadVal,
  output logic [CNT_W-1:0]    count,
  output logic                isZero
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          count <= '0;
    else if (clear)     count <= '0;
    else if (strb.load) count <= loadVal;
    else if (strb.dec)  count <= count - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign isZero = (count == '0);

  // R1
  load_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !clear) |=> count == $past(loadVal));
  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.load && !clear) |=> count == $past(count) - 1'b1);
  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dec && !strb.load && !clear) |=> $stable(count));
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> count == '0);
endmodule

// File: rtl/dly_control.sv
module dly_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                unitEn,
  input  logic                startWr,
  input  logic                stopWr,
  input  logic                tick,
  input  logic                edgeHit,
  input  logic                isZero,
  output dly_pkg::dlyStrobe_t strb,
  output logic                enabled,
  output logic                irq
);
  logic running, trig, stepOk, irqNext;

  assign trig    = startWr | (enabled & edgeHit);
  assign stepOk  = unitEn & ~stopWr & ~trig & running & tick;
  assign irqNext = stepOk & isZero;

  assign strb.load = unitEn & ~stopWr & trig;
  assign strb.dec  = stepOk & ~isZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled <= 1'b0;
      running <= 1'b0;
      irq     <= 1'b0;
    end else if (!unitEn) begin
      enabled <= 1'b0;
      running <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= irqNext;
      if (stopWr) begin
        enabled <= 1'b0;
        running <= 1'b0;
      end else if (trig) begin
        enabled <= 1'b1;
        running <= 1'b1;
      end else if (irqNext) begin
        running <= 1'b0;
      end
    end
  end

  // R5
  stop_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !enabled);
  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R3
  irq_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !running);
  // R7
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !startWr) |-> !strb.load);
endmodule

// File: rtl/delay_timer_channel.sv
module delay_timer_channel #(
  parameter int CNT_W       = dly_pkg::CNT_W,
  parameter int NUM_TICKS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         unitEn,
  input  logic                         startWr,
  input  logic                         stopWr,
  input  logic [CNT_W-1:0]             delayData,
  input  logic [$clog2(NUM_TICKS)-1:0] clkSel,
  input  logic [NUM_TICKS-1:0]         tickEn,
  input  logic [1:0]                   edgeSel,
  input  logic                         filtEn,
  input  logic                         trigIn,
  output logic [CNT_W-1:0]             countVal,
  output logic                         enabled,
  output logic                         irq
);
  dly_pkg::dlyStrobe_t strb;
  logic tick, edgeHit, isZero, clear;

  assign clear = ~unitEn;
  assign tick  = tickEn[clkSel];

  trig_edge_det #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_edge (
    .clk(clk), .rstN(rstN), .clear(clear), .pinIn(trigIn),
    .filtEn(filtEn), .edgeSel(edgeSel), .edgeHit(edgeHit)
  );

  dly_control u_ctrl (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .startWr(startWr),
    .stopWr(stopWr), .tick(tick), .edgeHit(edgeHit), .isZero(isZero),
    .strb(strb), .enabled(enabled), .irq(irq)
  );

  dly_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .clear(clear), .strb(strb),
    .loadVal(delayData), .count(countVal), .isZero(isZero)
  );
endmodule

// File: tb/delay_timer_channel_tb.sv
module delay_timer_channel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        unitEn = 1'b1;
  logic        startWr = 1'b0;
  logic        stopWr = 1'b0;
  logic [15:0] delayData = '0;
  logic [1:0]  clkSel = '0;
  logic [3:0]  tickEn = '0;
  logic [1:0]  edgeSel = '0;
  logic        filtEn = 1'b0;
  logic        trigIn = 1'b0;
  logic [15:0] countVal;
  logic        enabled, irq;

  int nChk = 0;
  int nFail = 0;

  // model state
  logic        mEn, mRun, mIrq;
  logic [15:0] mCnt;

  always #2 clk = ~clk;

  delay_timer_channel u_dut (
    .clk(clk), .rstN(rstN), .unitEn(unitEn), .startWr(startWr),
    .stopWr(stopWr), .delayData(delayData), .clkSel(clkSel),
    .tickEn(tickEn), .edgeSel(edgeSel), .filtEn(filtEn), .trigIn(trigIn),
    .countVal(countVal), .enabled(enabled), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // next model state from current inputs (R1..R5, R10)
  function automatic void modelStep();
    logic tk;
    tk = tickEn[clkSel];
    mIrq = 1'b0;
    if (stopWr) begin
      mEn = 1'b0; mRun = 1'b0;
    end else if (startWr) begin
      mEn = 1'b1; mRun = 1'b1; mCnt = delayData;
    end else if (mRun && tk) begin
      if (mCnt == 16'd0) begin mIrq = 1'b1; mRun = 1'b0; end
      else mCnt = mCnt - 16'd1;
    end
  endfunction

  task automatic pulseStart(input logic [15:0] d);
    delayData = d; startWr = 1'b1;
    @(negedge clk); startWr = 1'b0;
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    process::self().srandom(32'd1234);
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R9 reset state
    chk(countVal == 0 && !enabled && !irq, "R9 reset", countVal, 0);

    // R1 start
    pulseStart(16'd5);
    chk(enabled == 1'b1, "R1 enable", enabled, 1);
    chk(countVal == 16'd5, "R1 load", countVal, 5);

    // R2 unselected tick ignored
    clkSel = 2'd1; tickEn = 4'b0001;
    cyc(3);
    chk(countVal == 16'd5, "R2 unselected", countVal, 5);

    // R2/R3 countdown and pulse
    clkSel = 2'd0;
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk);
      chk(countVal == i && !irq, "R2 step", countVal, i);
    end
    @(negedge clk);
    chk(irq == 1'b1, "R3 pulse", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0 && countVal == 0, "R3 single", irq, 0);
    cyc(3);
    chk(countVal == 0 && !irq, "R3 halted", countVal, 0);

    // R3 zero delay: pulse on first tick
    tickEn = 4'b0000;
    pulseStart(16'd0);
    tickEn = 4'b0001;
    @(negedge clk);
    chk(irq == 1'b1, "R3 zero delay", irq, 1);
    tickEn = 4'b0000;

    // R4 retrigger, R10 delay rewrite
    pulseStart(16'd9);
    tickEn = 4'b0001;
    cyc(3);
    chk(countVal == 16'd6, "R4 running", countVal, 6);
    delayData = 16'd20;
    @(negedge clk);
    chk(countVal == 16'd5, "R10 no effect", countVal, 5);
    pulseStart(16'd20);
    chk(countVal == 16'd20, "R4 reload", countVal, 20);

    // R5 stop freezes
    stopWr = 1'b1;
    @(negedge clk); stopWr = 1'b0;
    held = countVal;
    chk(!enabled, "R5 disabled", enabled, 0);
    cyc(4);
    chk(countVal == held, "R5 frozen", countVal, held);
    tickEn = 4'b0000;

    // R7 pin edges ignored while disabled
    edgeSel = 2'd3; trigIn = 1'b1; delayData = 16'd44;
    cyc(8);
    chk(countVal == held, "R7 ignored", countVal, held);

    // R6 rising edge
    pulseStart(16'd100);
    trigIn = 1'b0; edgeSel = 2'd1;
    cyc(8);
    delayData = 16'd55; trigIn = 1'b1;
    cyc(8);
    chk(countVal == 16'd55, "R6 rising", countVal, 55);
    // R6 rising mode ignores falling edge
    delayData = 16'd66; trigIn = 1'b0;
    cyc(8);
    chk(countVal == 16'd55, "R6 falling ignored", countVal, 55);
    // R6 falling mode
    trigIn = 1'b1; edgeSel = 2'd2;
    cyc(8);
    chk(countVal == 16'd55, "R6 rising ignored", countVal, 55);
    delayData = 16'd77; trigIn = 1'b0;
    cyc(8);
    chk(countVal == 16'd77, "R6 falling", countVal, 77);
    // R6 latency: load three clocks after the sampling edge
    edgeSel = 2'd1; delayData = 16'd88; trigIn = 1'b1;
    cyc(3);
    chk(countVal == 16'd77, "R6 latency early", countVal, 77);
    cyc(1);
    chk(countVal == 16'd88, "R6 latency", countVal, 88);
    // R6 none mode
    edgeSel = 2'd0; delayData = 16'd11; trigIn = 1'b0;
    cyc(8);
    chk(countVal == 16'd88, "R6 none", countVal, 88);

    // R8 filter rejects one-clock glitch
    edgeSel = 2'd1; filtEn = 1'b1; delayData = 16'd12;
    cyc(8);
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    cyc(10);
    chk(countVal == 16'd88, "R8 glitch filtered", countVal, 88);
    trigIn = 1'b1;
    cyc(10);
    chk(countVal == 16'd12, "R8 stable passes", countVal, 12);
    trigIn = 1'b0; cyc(10);
    filtEn = 1'b0; delayData = 16'd13;
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    cyc(10);
    chk(countVal == 16'd13, "R8 glitch unfiltered", countVal, 13);

    // R9 unit disable
    unitEn = 1'b0; @(negedge clk); unitEn = 1'b1;
    chk(countVal == 0 && !enabled && !irq, "R9 unit clear", countVal, 0);

    // random phase vs model
    edgeSel = 2'd0;
    mEn = 1'b0; mRun = 1'b0; mIrq = 1'b0; mCnt = '0;
    for (int i = 0; i < 4000; i++) begin
      chk(countVal == mCnt, "R2 R3 R4 R10 random count", countVal, mCnt);
      chk(enabled == mEn, "R1 R5 random enable", enabled, mEn);
      chk(irq == mIrq, "R3 random irq", irq, mIrq);
      startWr = ($urandom_range(0, 19) == 0);
      stopWr  = ($urandom_range(0, 39) == 0);
      tickEn  = 4'($urandom);
      if ($urandom_range(0, 63) == 0) clkSel = 2'($urandom);
      if ($urandom_range(0, 7) == 0) delayData = 16'($urandom_range(0, 12));
      modelStep();
      @(negedge clk);
    end
    startWr = 1'b0; stopWr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule